// File: doc/BRIEF.md
# Trimmed Real-Time Clock Prescaler with Sub-Second Index and Rate Tick

This block turns a slow oscillator clock enable, nominally 32.768 kHz, into a one-second strobe. The division is trimmed to the oscillator's measured frequency. A 5-bit integer code selects a whole-number divisor of `BASE_DIV + code`, which is 32752 to 32783 with the default parameters. A 6-bit fraction, in units of 1/64 of an input cycle, feeds an accumulator. Each second the accumulator adds the fraction, and when it overflows the following second is one input cycle longer. Averaged over time, the second therefore follows the measured frequency to within 1/64 of a cycle.

Each second is split into 128 sub-second steps that are spread as evenly as the whole-cycle grid allows. A 7-bit index counts these steps. A periodic tick, selected by a 3-bit code, fires when the index reaches a multiple of `128 >> code`, which gives between one and 128 ticks per second.

Nothing counts until a 32-bit unlock word has been written. After the unlock the block stays running until the next power-on reset. The read-back word shows only the running status.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: While reset is released but the block has not been unlocked, `active`, `sec_pulse` and `tick_pulse` stay 0 and `subsec` stays 0, even when `clk32_en` is high.
- R2: A write whose data is not 32'hA5EB1357 leaves the block locked, and nothing starts counting afterwards.
- R3: A write of 32'hA5EB1357 sets `active` in the next cycle. `active` then stays 1 until `rst_n` is asserted, and later writes of any value do not change or restart the count.
- R4: `init_rdata` bit 0 equals `active`, and bits 31:1 always read 0.
- R5: With no fractional carry, a second lasts `BASE_DIV + comp_int` counted enables. The first second starts with the enable in the cycle after the unlock write.
- R6: At each second strobe the 6-bit accumulator adds `comp_frac`. A carry out of bit 5 makes the following second one counted enable longer. The accumulator starts at 0 when the block is unlocked.
- R7: The second length is fixed at the start of each second. A change of `comp_int` during a second takes effect only from the next second.
- R8: Only cycles with `clk32_en` high advance any count. Nothing changes on other cycles.
- R9: After j counted enables into a second of length D, `subsec` equals floor(128*j/D) mod 128. It only ever steps up by one, and its wrap to 0 happens in the same cycle as `sec_pulse`.
- R10: `tick_pulse` is high for one cycle whenever `subsec` steps to a value whose low (7 - `tick_sel`) bits are all 0. This gives 2^`tick_sel` ticks per second, one of them in the same cycle as `sec_pulse`.
- R11: `sec_pulse` is one cycle wide. It is high in the cycle after the edge that counted the last enable of the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| clk32_en | input | 1 | Enable, one cycle per oscillator period |
| init_wr | input | 1 | Write strobe for the unlock word |
| init_wdata | input | 32 | Unlock write data |
| comp_int | input | INT_W | Integer trim code; divisor is BASE_DIV + code |
| comp_frac | input | FRAC_W | Fractional trim in 1/64 cycle units |
| tick_sel | input | SEL_W | Tick rate code; 2^code ticks per second |
| active | output | 1 | Block is unlocked and counting |
| init_rdata | output | 32 | Read-back word: running status in bit 0, zeros above |
| sec_pulse | output | 1 | One-cycle second strobe |
| subsec | output | SUB_W | Sub-second index, 0 to 127 |
| tick_pulse | output | 1 | One-cycle periodic tick |

## Verification
`active` is due one cycle after the edge that takes the unlock write. `subsec`, `tick_pulse` and `sec_pulse` all update at the edge that counts the enable causing them, so they can be seen in the low phase that follows. The bench drives every input at the falling edge and samples at the next falling edge. It counts the enables it has itself driven, so each second length, each expected index floor(128*j/D) and each expected tick is predicted from that count. The expected length of the next second comes from a model of the fraction accumulator that the bench keeps on its own. The model is updated at each observed strobe, using the trim values in force at that strobe.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  typedef logic [31:0] word_t;
  localparam word_t UNLOCK_KEY = 32'hA5EB1357;
endpackage

// File: rtl/rtc_key_gate.sv
module rtc_key_gate
  import rtc_trim_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  word_t wdata,
  output logic  active,
  output logic  start
);
  logic active_q;

  // A start event happens once: the correct word arriving while locked.
  assign start  = wr && (wdata == UNLOCK_KEY) && !active_q;
  assign active = active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     active_q <= 1'b0;
    else if (start) active_q <= 1'b1;
  end
endmodule

// File: rtl/rtc_frac_divider.sv
module rtc_frac_divider #(
  parameter int BASE   = 32752,
  parameter int INT_W  = 5,
  parameter int FRAC_W = 6,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              en_act,
  input  logic [INT_W-1:0]  comp_int,
  input  logic [FRAC_W-1:0] comp_frac,
  output logic [DIV_W-1:0]  div_len,
  output logic              sec_last,
  output logic              sec_pulse
);
  logic [DIV_W-1:0]  cnt_q, div_q;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic              pulse_q;

  // Length of one second in counted enables.
  function automatic logic [DIV_W-1:0] period_of(input logic [INT_W-1:0] code,
                                                 input logic extra);
    return DIV_W'(BASE) + DIV_W'(code) + DIV_W'(extra);
  endfunction

  assign acc_sum   = {1'b0, acc_q} + {1'b0, comp_frac};
  assign sec_last  = en_act && (cnt_q == div_q - 1'b1);
  assign div_len   = div_q;
  assign sec_pulse = pulse_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      div_q   <= DIV_W'(BASE);
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else if (start) begin
      cnt_q   <= '0;
      div_q   <= period_of(comp_int, 1'b0);
      acc_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= sec_last;
      if (en_act) begin
        if (sec_last) begin
          cnt_q <= '0;
          acc_q <= acc_sum[FRAC_W-1:0];
          div_q <= period_of(comp_int, acc_sum[FRAC_W]);
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rtc_subsec_index.sv
module rtc_subsec_index #(
  parameter int SUB_W = 7,
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             en_act,
  input  logic             sec_last,
  input  logic [DIV_W-1:0] div_len,
  output logic             step,
  output logic [SUB_W-1:0] idx_next,
  output logic [SUB_W-1:0] subsec
);
  localparam logic [DIV_W:0] STRIDE = (DIV_W+1)'(2**SUB_W);

  logic [DIV_W:0]   res_q, res_sum;
  logic [SUB_W-1:0] idx_q;

  // Residue stepping: add the step count per enable, spend one divisor per step.
  assign res_sum  = res_q + STRIDE;
  assign step     = en_act && (res_sum >= {1'b0, div_len});
  assign idx_next = idx_q + 1'b1;
  assign subsec   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      idx_q <= '0;
    end else if (start) begin
      res_q <= '0;
      idx_q <= '0;
    end else if (en_act) begin
      if (sec_last) begin
        res_q <= '0;
        idx_q <= '0;
      end else if (step) begin
        res_q <= res_sum - {1'b0, div_len};
        idx_q <= idx_next;
      end else begin
        res_q <= res_sum;
      end
    end
  end
endmodule

// File: rtl/rtc_tick_select.sv
module rtc_tick_select #(
  parameter int SUB_W = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             step,
  input  logic [SUB_W-1:0] idx_next,
  input  logic [SEL_W-1:0] tick_sel,
  output logic             tick_pulse
);
  logic [SUB_W-1:0] mask;
  logic             tick_q;

  // Low bits that must reach zero for a tick at this rate code.
  function automatic logic [SUB_W-1:0] low_mask(input logic [SEL_W-1:0] code);
    return {SUB_W{1'b1}} >> code;
  endfunction

  assign mask       = low_mask(tick_sel);
  assign tick_pulse = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tick_q <= 1'b0;
    else if (start) tick_q <= 1'b0;
    else            tick_q <= step && ((idx_next & mask) == '0);
  end
endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import rtc_trim_pkg::*;
#(
  parameter int BASE_DIV = 32752,
  parameter int INT_W    = 5,
  parameter int FRAC_W   = 6,
  parameter int SUB_W    = 7,
  parameter int SEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk32_en,
  input  logic              init_wr,
  input  logic [31:0]       init_wdata,
  input  logic [INT_W-1:0]  comp_int,
  input  logic [FRAC_W-1:0] comp_frac,
  input  logic [SEL_W-1:0]  tick_sel,
  output logic              active,
  output logic [31:0]       init_rdata,
  output logic              sec_pulse,
  output logic [SUB_W-1:0]  subsec,
  output logic              tick_pulse
);
  localparam int DIV_W = $clog2(BASE_DIV + 2**INT_W + 1);

  logic             start;
  logic             en_act;
  logic             sec_last;
  logic             sub_step;
  logic [DIV_W-1:0] div_len;
  logic [SUB_W-1:0] idx_next;

  rtc_key_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (init_wr),
    .wdata  (init_wdata),
    .active (active),
    .start  (start)
  );

  assign en_act     = active & clk32_en;
  assign init_rdata = {31'b0, active};

  rtc_frac_divider #(
    .BASE(BASE_DIV), .INT_W(INT_W), .FRAC_W(FRAC_W), .DIV_W(DIV_W)
  ) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .en_act    (en_act),
    .comp_int  (comp_int),
    .comp_frac (comp_frac),
    .div_len   (div_len),
    .sec_last  (sec_last),
    .sec_pulse (sec_pulse)
  );

  rtc_subsec_index #(.SUB_W(SUB_W), .DIV_W(DIV_W)) u_sub (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .en_act   (en_act),
    .sec_last (sec_last),
    .div_len  (div_len),
    .step     (sub_step),
    .idx_next (idx_next),
    .subsec   (subsec)
  );

  rtc_tick_select #(.SUB_W(SUB_W), .SEL_W(SEL_W)) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .step       (sub_step),
    .idx_next   (idx_next),
    .tick_sel   (tick_sel),
    .tick_pulse (tick_pulse)
  );
endmodule

// File: rtl/rtc_trim_prescaler_chk.sv
module rtc_trim_prescaler_chk #(
  parameter int SUB_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             active,
  input logic [31:0]      init_rdata,
  input logic             en_act,
  input logic             sec_last,
  input logic             sub_step,
  input logic             sec_pulse,
  input logic [SUB_W-1:0] subsec,
  input logic             tick_pulse
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!sec_pulse && !tick_pulse && subsec == '0)); // R1

  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    active |=> active); // R3

  AST_READ_ZERO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    init_rdata[0] == active); // R4

  AST_HOLD_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_act |=> $stable(subsec)); // R8

  AST_LAST_IS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_last |-> sub_step); // R9

  AST_WRAP_AT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> (subsec == '0)); // R9

  AST_INDEX_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !$stable(subsec)) |-> (subsec == $past(subsec) + 1'b1)); // R9

  AST_TICK_AT_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> tick_pulse); // R10

  AST_SEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse); // R11
endmodule

bind rtc_trim_prescaler rtc_trim_prescaler_chk #(.SUB_W(SUB_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .active     (active),
  .init_rdata (init_rdata),
  .en_act     (en_act),
  .sec_last   (sec_last),
  .sub_step   (sub_step),
  .sec_pulse  (sec_pulse),
  .subsec     (subsec),
  .tick_pulse (tick_pulse)
);

// File: tb/tb_rtc_trim_prescaler.sv
`timescale 1ns/1ps
module tb_rtc_trim_prescaler;
  localparam int BASE = 256;
  localparam logic [31:0] KEY = 32'hA5EB1357;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clk32_en = 1'b1;
  logic        init_wr = 1'b0;
  logic [31:0] init_wdata = '0;
  logic [4:0]  comp_int = 5'd3;
  logic [5:0]  comp_frac = '0;
  logic [2:0]  tick_sel = '0;
  logic        active;
  logic [31:0] init_rdata;
  logic        sec_pulse;
  logic [6:0]  subsec;
  logic        tick_pulse;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  last_en = 1'b1;
  bit  from_pulse = 1'b0;
  int  model_acc = 0;
  int  exp_len = 0;
  bit  exp_extra = 1'b0;

  rtc_trim_prescaler #(.BASE_DIV(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .clk32_en(clk32_en), .init_wr(init_wr),
    .init_wdata(init_wdata), .comp_int(comp_int), .comp_frac(comp_frac),
    .tick_sel(tick_sel), .active(active), .init_rdata(init_rdata),
    .sec_pulse(sec_pulse), .subsec(subsec), .tick_pulse(tick_pulse)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R1 / R2: stay locked for n cycles, enables high
  task automatic t_locked(input int n, input string req);
    bit quiet = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (active || sec_pulse || tick_pulse || subsec != 0) quiet = 1'b0;
    end
    chk(quiet, req, active, 0);
  endtask

  task automatic t_write(input logic [31:0] data);
    @(negedge clk);
    init_wr = 1'b1;
    init_wdata = data;
    @(negedge clk);
    init_wr = 1'b0;
    init_wdata = '0;
  endtask

  // One second: counts enables, checks length, index, ticks.
  task automatic t_second(input string len_req, input int mid_at, input int mid_int,
                          input bit mid_key, input bit gap);
    int j = 0, cyc = 0, ticks = 0;
    bit seen = 1'b0, sub_ok = 1'b1, tick_ok = 1'b1;
    logic [6:0] prev = subsec;
    logic [6:0] exp_sub, mask;
    int sum;
    while (!seen && cyc < 4 * exp_len + 20) begin
      @(negedge clk);
      cyc++;
      if (init_wr) begin init_wr = 1'b0; init_wdata = '0; end
      if (last_en) j++;
      if (cyc == 1 && from_pulse) chk(!sec_pulse, "R11 strobe width", sec_pulse, 0);
      exp_sub = 7'((128 * j) / exp_len);
      if (subsec !== exp_sub) sub_ok = 1'b0;
      mask = 7'h7F >> tick_sel;
      if (tick_pulse !== ((subsec != prev) && ((subsec & mask) == 0))) tick_ok = 1'b0;
      if (tick_pulse) ticks++;
      prev = subsec;
      if (sec_pulse) seen = 1'b1;
      if (!seen && mid_at == j && last_en) begin
        if (mid_key) begin init_wr = 1'b1; init_wdata = mid_key ? KEY : '0; end
        else comp_int = 5'(mid_int);
      end
      clk32_en = gap ? ~clk32_en : 1'b1;
      last_en = clk32_en;
    end
    chk(seen && j == exp_len, len_req, j, exp_len);
    chk(sub_ok, "R9 sub-second index", subsec, 0);
    chk(tick_ok && ticks == (1 << tick_sel), "R10 tick count", ticks, 1 << tick_sel);
    chk(tick_pulse === 1'b1, "R10 tick with strobe", tick_pulse, 1);
    from_pulse = 1'b1;
    // advance independent model with the trim values in force at the strobe
    sum = model_acc + int'(comp_frac);
    exp_extra = (sum >= 64);
    model_acc = sum % 64;
    exp_len = BASE + int'(comp_int) + (exp_extra ? 1 : 0);
  endtask

  function automatic string len_tag();
    return exp_extra ? "R6 stretched second" : "R5 second length";
  endfunction

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(active == 0 && sec_pulse == 0 && subsec == 0, "R1 reset state", active, 0);
    chk(init_rdata == 0, "R4 read-back locked", init_rdata, 0);
    t_locked(20, "R1 enables ignored while locked");
    // R2 wrong words
    t_write(32'h12345678);
    t_locked(20, "R2 wrong word ignored");
    t_write(KEY ^ 32'h1);
    t_locked(20, "R2 near-miss word ignored");
    // R3 unlock
    t_write(KEY);
    chk(active == 1'b1, "R3 unlock", active, 1);
    chk(init_rdata == 32'h1, "R4 read-back active", init_rdata, 1);
    last_en = clk32_en;
    model_acc = 0; exp_extra = 1'b0;
    exp_len = BASE + int'(comp_int);
    t_second("R5 first second", -1, 0, 1'b0, 1'b0);
    tick_sel = 3'd3;
    t_second(len_tag(), -1, 0, 1'b0, 1'b0);
    // R6 fraction carries
    tick_sel = 3'd7;
    comp_frac = 6'd16;
    for (int k = 0; k < 5; k++) t_second(len_tag(), -1, 0, 1'b0, 1'b0);
    comp_frac = 6'd63; comp_int = 5'd31; tick_sel = 3'd1;
    for (int k = 0; k < 3; k++) t_second(len_tag(), -1, 0, 1'b0, 1'b0);
    // R7 mid-second change
    comp_frac = 6'd0; comp_int = 5'd0;
    t_second(len_tag(), -1, 0, 1'b0, 1'b0);
    t_second("R7 mid-second trim change", 60, 20, 1'b0, 1'b0);
    t_second("R7 new trim applies", -1, 0, 1'b0, 1'b0);
    // R8 gapped enables
    tick_sel = 3'd2;
    t_second("R8 gapped enables", -1, 0, 1'b0, 1'b1);
    // R3 rewrite key mid-second has no effect
    clk32_en = 1'b1; last_en = 1'b1;
    t_second("R3 rewrite does not restart", 80, 0, 1'b1, 1'b0);
    t_write(32'h0);
    chk(active == 1'b1, "R3 stays active", active, 1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 run did not finish actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule